// File: doc/BRIEF.md
# Sprite Row Serializer and Pixel Priority Mixer

This block sits at the back end of a tile-based video pipeline. During horizontal blanking, the fetch logic writes up to eight sprite rows into its slots. Each row carries two pattern bit-planes, a two-bit palette number, a behind-background bit, an X position, a mirror flag, a valid flag and, for slot 0, a flag saying the row belongs to the first object-table entry. While the visible part of a line is drawn, every pixel clock does three things: each slot counts down to its X position, the slot then sends out its eight pixels, and the lowest-numbered opaque slot wins.

The winning sprite pixel is then combined with the playfield pixel of the same clock. The result is a 4-bit palette index plus a bit that selects either the sprite palette or the playfield palette. The sprites are ranked among themselves before the playfield is considered. Because of that, a low-numbered sprite that is marked behind the background can hide a higher-numbered foreground sprite, and the playfield then shows through in its place. A sticky hit flag records a pixel where a winning slot-0 sprite pixel and an opaque playfield pixel are both present. The flag is cleared by a frame-start pulse.

Top module: `spr_pix_mux`

## Requirements
- R1: After reset every slot is transparent, `pal_sel` is 0, `pal_idx` equals `pf_pix`, and `coll` is 0.
- R2: A slot loaded with X = x is transparent for its first x enabled pixel clocks after the load. It sends out its pixels on enabled clocks x to x+7 and is transparent after that.
- R3: Without mirroring, the pixel on the k-th emitted clock (k = 0..7) is {high-plane bit 7-k, low-plane bit 7-k}. Both pattern bytes are sent most significant bit first.
- R4: With `ld_flip` set at load, the k-th emitted pixel is {high-plane bit k, low-plane bit k}.
- R5: A slot loaded with `ld_valid` = 0 stays transparent for the whole line, whatever pattern bytes are given.
- R6: Among slots whose current pixel is non-zero, the lowest-numbered one wins. When all slots are transparent, no sprite pixel is shown.
- R7: When the winning sprite pixel p is non-zero and either its behind bit is 0 or `pf_pix[1:0]` is 0, the output is `pal_sel` = 1 with `pal_idx` = {palette[1:0], p}. In every other case the output is `pal_sel` = 0 with `pal_idx` = `pf_pix`.
- R8: If an opaque behind-background sprite in a lower slot overlaps an opaque foreground sprite in a higher slot, and the playfield is opaque, the playfield pixel is shown.
- R9: `coll` becomes 1 one clock after an enabled pixel in which slot 0 wins with a non-zero pixel, was loaded with `ld_zero` = 1, and `pf_pix[1:0]` is non-zero. It then stays 1.
- R10: `coll` is not set on a clock with `pix_en` low, nor when a slot other than slot 0 wins.
- R11: A `frame_start` pulse clears `coll` on the next clock. A clear in the same cycle as a hit takes precedence over the hit.
- R12: While `pix_en` and `ld_en` are both low, no slot changes its position and the outputs depend only on `pf_pix`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| ld_en | input | 1 | Load strobe for the slot selected by ld_slot |
| ld_slot | input | 3 | Slot number to load |
| ld_pat_lo | input | 8 | Low bit-plane of the sprite row |
| ld_pat_hi | input | 8 | High bit-plane of the sprite row |
| ld_pal | input | 2 | Sprite palette number |
| ld_behind | input | 1 | 1 = draw behind opaque playfield |
| ld_x | input | 8 | Horizontal start position |
| ld_flip | input | 1 | 1 = mirror the row horizontally |
| ld_valid | input | 1 | 0 = slot unused, load a transparent row |
| ld_zero | input | 1 | Row is the first object-table entry (used for slot 0 only) |
| pix_en | input | 1 | Visible-pixel enable |
| frame_start | input | 1 | Clears the hit flag |
| pf_pix | input | 4 | Playfield pixel, bits [1:0] zero = transparent |
| pal_idx | output | 4 | Palette index for this pixel |
| pal_sel | output | 1 | 1 = sprite palette, 0 = playfield palette |
| coll | output | 1 | Sticky slot-0 / playfield hit flag |

## Verification
The bench sweeps every X position from 0 to 255, alternating between mirrored and plain rows and rotating through the slots. A counter that is off by one shifts the whole row by one pixel, and a wrong shift direction or bit order scrambles the pixels inside the row. Randomized lines pause `pix_en` at random, overlap several slots and drive random playfield pixels. These lines catch a chain that prefers the wrong slot, a mixer that ranks the playfield before the sprites, a hit flag that fires while paused or through a slot other than 0, and positions that drift during pauses. Directed cases cover the behind-sprite quirk, where a wrong design shows the foreground sprite. They also cover a clear arriving together with a hit, where a wrong design keeps the flag set.

// File: rtl/spr_mix_pkg.sv
package spr_mix_pkg;

  // Per-row drawing attributes kept beside the pattern shifters.
  typedef struct packed {
    logic [1:0] pal;     // sprite palette number
    logic       behind;  // 1: yields to opaque playfield
  } spr_attr_t;

  localparam logic [1:0] PX_CLEAR = 2'b00;

endpackage

// File: rtl/spr_slot.sv
module spr_slot
  import spr_mix_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int X_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PAT_W-1:0] ld_lo,
  input  logic [PAT_W-1:0] ld_hi,
  input  spr_attr_t        ld_attr,
  input  logic [X_W-1:0]   ld_x,
  input  logic             ld_flip,
  input  logic             ld_valid,
  input  logic             pix_en,
  output logic [1:0]       px,
  output spr_attr_t        attr
);

  localparam int RUN_W = $clog2(PAT_W + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(PAT_W);

  logic [PAT_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [PAT_W-1:0] lo_rev, hi_rev;
  logic [X_W-1:0]   cnt_q, cnt_d;
  logic [RUN_W-1:0] run_q, run_d;
  spr_attr_t        attr_q, attr_d;
  logic             upd;
  logic             emitting;

  for (genvar b = 0; b < PAT_W; b++) begin : g_rev
    assign lo_rev[b] = ld_lo[PAT_W-1-b];
    assign hi_rev[b] = ld_hi[PAT_W-1-b];
  end

  assign emitting = (cnt_q == '0) && (run_q != '0);
  assign upd      = ld | pix_en;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    attr_d = attr_q;
    if (ld) begin
      lo_d   = !ld_valid ? '0 : (ld_flip ? lo_rev : ld_lo);
      hi_d   = !ld_valid ? '0 : (ld_flip ? hi_rev : ld_hi);
      cnt_d  = ld_x;
      run_d  = RUN_FULL;
      attr_d = ld_attr;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (run_q != '0) begin
      lo_d  = {lo_q[PAT_W-2:0], 1'b0};
      hi_d  = {hi_q[PAT_W-2:0], 1'b0};
      run_d = run_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cnt_q  <= '0;
      run_q  <= '0;
      attr_q <= '0;
    end else if (upd) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      attr_q <= attr_d;
    end
  end

  assign px   = emitting ? {hi_q[PAT_W-1], lo_q[PAT_W-1]} : PX_CLEAR;
  assign attr = attr_q;

  // R2
  delay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_x != '0) |=> (px == PX_CLEAR));

  // R5
  unused_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_valid) |=> (px == PX_CLEAR));

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !pix_en) |=> $stable(px));

endmodule

// File: rtl/spr_prio.sv
module spr_prio
  import spr_mix_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0][1:0] px,
  input  spr_attr_t [N-1:0] attr,
  input  logic              zero0,
  output logic [1:0]        win_px,
  output spr_attr_t         win_attr,
  output logic              win_zero
);

  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] win;

  // Fixed chain: scan from the top so the lowest opaque slot is kept;
  // the last slot is the default when nothing ahead of it is opaque.
  always_comb begin
    win = IDX_W'(N - 1);
    for (int i = N - 2; i >= 0; i--) begin
      if (px[i] != PX_CLEAR) win = IDX_W'(i);
    end
  end

  assign win_px   = px[win];
  assign win_attr = attr[win];
  assign win_zero = zero0 && (win == '0);

endmodule

// File: rtl/pix_mixer.sv
module pix_mixer
  import spr_mix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_en,
  input  logic       frame_start,
  input  logic [1:0] spr_px,
  input  spr_attr_t  spr_attr,
  input  logic       spr_zero,
  input  logic [3:0] pf_pix,
  output logic [3:0] pal_idx,
  output logic       pal_sel,
  output logic       coll
);

  logic pf_opaque, spr_opaque, use_spr;
  logic hit, coll_q, coll_d, coll_en;

  assign pf_opaque  = (pf_pix[1:0] != 2'b00);
  assign spr_opaque = (spr_px != PX_CLEAR);
  assign use_spr    = spr_opaque && (!spr_attr.behind || !pf_opaque);

  assign pal_sel = use_spr;
  assign pal_idx = use_spr ? {spr_attr.pal, spr_px} : pf_pix;

  assign hit     = pix_en && spr_zero && spr_opaque && pf_opaque;
  assign coll_en = frame_start | hit;
  assign coll_d  = !frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       coll_q <= 1'b0;
    else if (coll_en) coll_q <= coll_d;
  end

  assign coll = coll_q;

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !coll);

  // R10
  set_when_drawing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll) |-> $past(pix_en));

  // R9
  sticky_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !frame_start) |=> coll);

endmodule

// File: rtl/spr_pix_mux.sv
module spr_pix_mux
  import spr_mix_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PAT_W     = 8,
  parameter int X_W       = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [PAT_W-1:0]  ld_pat_lo,
  input  logic [PAT_W-1:0]  ld_pat_hi,
  input  logic [1:0]        ld_pal,
  input  logic              ld_behind,
  input  logic [X_W-1:0]    ld_x,
  input  logic              ld_flip,
  input  logic              ld_valid,
  input  logic              ld_zero,
  input  logic              pix_en,
  input  logic              frame_start,
  input  logic [3:0]        pf_pix,
  output logic [3:0]        pal_idx,
  output logic              pal_sel,
  output logic              coll
);

  logic [NUM_SLOTS-1:0][1:0] slot_px;
  spr_attr_t [NUM_SLOTS-1:0] slot_attr;
  spr_attr_t                 ld_attr;
  logic [1:0]                win_px;
  spr_attr_t                 win_attr;
  logic                      win_zero;
  logic                      zero0_q, zero0_en;

  assign ld_attr = '{pal: ld_pal, behind: ld_behind};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    spr_slot #(.PAT_W(PAT_W), .X_W(X_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld_en && (ld_slot == SLOT_W'(i))),
      .ld_lo    (ld_pat_lo),
      .ld_hi    (ld_pat_hi),
      .ld_attr  (ld_attr),
      .ld_x     (ld_x),
      .ld_flip  (ld_flip),
      .ld_valid (ld_valid),
      .pix_en   (pix_en),
      .px       (slot_px[i]),
      .attr     (slot_attr[i])
    );
  end

  // First-entry marker exists only for the highest-priority slot.
  assign zero0_en = ld_en && (ld_slot == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        zero0_q <= 1'b0;
    else if (zero0_en) zero0_q <= ld_zero && ld_valid;
  end

  spr_prio #(.N(NUM_SLOTS)) prio_i (
    .px       (slot_px),
    .attr     (slot_attr),
    .zero0    (zero0_q),
    .win_px   (win_px),
    .win_attr (win_attr),
    .win_zero (win_zero)
  );

  pix_mixer mix_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .frame_start (frame_start),
    .spr_px      (win_px),
    .spr_attr    (win_attr),
    .spr_zero    (win_zero),
    .pf_pix      (pf_pix),
    .pal_idx     (pal_idx),
    .pal_sel     (pal_sel),
    .coll        (coll)
  );

  // R6
  zero_only_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_zero |-> (slot_px[0] != PX_CLEAR));

  // R7
  sprite_sel_opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_sel |-> (pal_idx[1:0] != 2'b00));

endmodule

// File: tb/spr_pix_mux_tb.sv
`timescale 1ns/1ps
module spr_pix_mux_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_en, ld_behind, ld_flip, ld_valid, ld_zero;
  logic [2:0] ld_slot;
  logic [7:0] ld_pat_lo, ld_pat_hi, ld_x;
  logic [1:0] ld_pal;
  logic       pix_en, frame_start;
  logic [3:0] pf_pix;
  logic [3:0] pal_idx;
  logic       pal_sel, coll;

  always #2 clk = ~clk;

  spr_pix_mux dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_slot(ld_slot),
    .ld_pat_lo(ld_pat_lo), .ld_pat_hi(ld_pat_hi), .ld_pal(ld_pal),
    .ld_behind(ld_behind), .ld_x(ld_x), .ld_flip(ld_flip),
    .ld_valid(ld_valid), .ld_zero(ld_zero), .pix_en(pix_en),
    .frame_start(frame_start), .pf_pix(pf_pix), .pal_idx(pal_idx),
    .pal_sel(pal_sel), .coll(coll)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Bench model of loaded rows
  logic [7:0] m_lo [8];
  logic [7:0] m_hi [8];
  logic [7:0] m_x [8];
  logic [1:0] m_pal [8];
  bit m_flip [8];
  bit m_valid [8];
  bit m_behind [8];
  bit m_zero0;
  int m_pos [8];
  bit exp_coll;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] slot_pix(input int s);
    int k, b;
    if (!m_valid[s]) return 2'b00;
    if (m_pos[s] < int'(m_x[s]) || m_pos[s] >= int'(m_x[s]) + 8) return 2'b00;
    k = m_pos[s] - int'(m_x[s]);
    b = m_flip[s] ? k : 7 - k;
    return {m_hi[s][b], m_lo[s][b]};
  endfunction

  task automatic load_slot(input int s, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [1:0] pal, input bit behind, input logic [7:0] x,
                           input bit flip, input bit valid, input bit zero);
    @(negedge clk);
    pix_en = 0; frame_start = 0;
    ld_en = 1; ld_slot = 3'(s); ld_pat_lo = lo; ld_pat_hi = hi; ld_pal = pal;
    ld_behind = behind; ld_x = x; ld_flip = flip; ld_valid = valid; ld_zero = zero;
    @(negedge clk);
    ld_en = 0;
    m_lo[s] = lo; m_hi[s] = hi; m_pal[s] = pal; m_behind[s] = behind;
    m_x[s] = x; m_flip[s] = flip; m_valid[s] = valid; m_pos[s] = 0;
    if (s == 0) m_zero0 = zero && valid;
  endtask

  // One clock: drive, compare against model, then advance model.
  task automatic pix(input bit en, input logic [3:0] pf, input string req);
    int win;
    logic [1:0] wp;
    bit use_s, hit;
    logic [3:0] e_idx;
    @(negedge clk);
    pix_en = en; pf_pix = pf; frame_start = 0;
    #1;
    win = 7;
    for (int s = 6; s >= 0; s--) if (slot_pix(s) != 2'b00) win = s;
    wp = slot_pix(win);
    use_s = (wp != 0) && (!m_behind[win] || pf[1:0] == 0);
    e_idx = use_s ? {m_pal[win], wp} : pf;
    check(pal_sel == use_s, {req, " sel"}, int'(pal_sel), int'(use_s));
    check(pal_idx == e_idx, {req, " idx"}, int'(pal_idx), int'(e_idx));
    check(coll == exp_coll, "R9/R10 coll", int'(coll), int'(exp_coll));
    hit = en && (win == 0) && m_zero0 && (wp != 0) && (pf[1:0] != 0);
    if (hit) exp_coll = 1;
    if (en) for (int s = 0; s < 8; s++) m_pos[s]++;
  endtask

  task automatic clear_frame(input bit with_hit);
    @(negedge clk);
    frame_start = 1; pix_en = with_hit; pf_pix = 4'h3;
    @(negedge clk);
    frame_start = 0; pix_en = 0;
    if (with_hit) for (int s = 0; s < 8; s++) m_pos[s]++;
    exp_coll = 0;
    #1;
    check(coll == 0, "R11 clear", int'(coll), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_en = 0; ld_slot = 0; ld_pat_lo = 0; ld_pat_hi = 0; ld_pal = 0;
    ld_behind = 0; ld_x = 0; ld_flip = 0; ld_valid = 0; ld_zero = 0;
    pix_en = 0; frame_start = 0; pf_pix = 4'h6;
    for (int s = 0; s < 8; s++) begin
      m_valid[s] = 0; m_pos[s] = 0; m_x[s] = 0; m_lo[s] = 0; m_hi[s] = 0;
      m_pal[s] = 0; m_flip[s] = 0; m_behind[s] = 0;
    end
    m_zero0 = 0; exp_coll = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(pal_sel == 0, "R1 sel", int'(pal_sel), 0);
    check(pal_idx == 4'h6, "R1 idx", int'(pal_idx), 6);
    check(coll == 0, "R1 coll", int'(coll), 0);
    @(negedge clk); rst_n = 1;
    pix(1'b1, 4'h9, "R1 after reset");

    // R2 R3 R4 R5: every X position, plain and mirrored, one live slot
    for (int x = 0; x < 256; x++) begin
      for (int s = 0; s < 8; s++) begin
        if (s == x % 8)
          load_slot(s, 8'(x * 37 + 5), 8'(x * 91 + 200), 2'(x), x[2], 8'(x),
                    x[0], 1'b1, 1'b0);
        else
          load_slot(s, 8'hFF, 8'hFF, 2'd3, 1'b0, 8'(x), 1'b0, 1'b0, 1'b0);
      end
      for (int p = 0; p < 256; p++) pix(1'b1, 4'h0, "R2/R3/R4/R5 sweep");
    end

    // R8 quirk: behind sprite in slot 0 over foreground sprite in slot 1
    clear_frame(1'b0);
    load_slot(0, 8'hFF, 8'h00, 2'd1, 1'b1, 8'd4, 1'b0, 1'b1, 1'b1);
    load_slot(1, 8'hFF, 8'hFF, 2'd2, 1'b0, 8'd4, 1'b0, 1'b1, 1'b0);
    for (int s = 2; s < 8; s++) load_slot(s, 0, 0, 0, 0, 0, 0, 1'b0, 0);
    for (int p = 0; p < 4; p++) pix(1'b1, 4'h0, "R8 lead");
    pix(1'b1, 4'h5, "R8 quirk");
    #0;
    check(pal_sel == 0 && pal_idx == 4'h5, "R8 playfield shown", int'(pal_idx), 5);
    pix(1'b1, 4'h4, "R7 transparent pf");
    check(pal_idx == 4'h5 && pal_sel == 1, "R7 slot0 shown", int'(pal_idx), 5);
    // R9: hit from the quirk pixel is visible now and sticks
    pix(1'b0, 4'h0, "R12 idle");
    check(coll == 1, "R9 sticky", int'(coll), 1);
    // R11: clear together with a hit pixel
    clear_frame(1'b1);

    // Randomized lines: priority, mixing, pauses, hits (R6 R7 R9 R10 R12)
    for (int line = 0; line < 120; line++) begin
      logic [31:0] r;
      clear_frame(1'b0);
      for (int s = 0; s < 8; s++) begin
        r = rnd();
        load_slot(s, r[7:0], r[15:8], r[17:16], r[18], {2'b00, r[24:19]},
                  r[25], r[28:26] != 0, r[29]);
      end
      for (int p = 0; p < 90; p++) begin
        r = rnd();
        pix(r[1:0] != 0, r[7:4], "R6/R7/R10/R12 random");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule